// File: doc/BRIEF.md
# Boundary-Splitting Descriptor List Generator

This block turns a list of memory buffer segments, each an address and a byte length, into the descriptor table a scatter-gather DMA engine walks. Each segment is cut into pieces so that no piece crosses an aligned window of 2^BOUND_W bytes (64 KiB by default). Each piece becomes one 128-bit descriptor, sent as four 32-bit big-endian words. Segments enter on a valid/ready stream with a flag on the final segment of a list. Descriptor words leave on a second valid/ready stream.

One descriptor is always kept back in a register until the generator knows whether another one follows. This lets the end-of-list marker go into the final descriptor before that descriptor leaves. When a list is finished, a status pulse gives the number of descriptors in the table.

If a list needs more descriptors than the table can hold, the job is abandoned. The status then reports zero entries and an overflow, so the requester can move the data without DMA.

Top module: `sg_desc_builder`

## Requirements
- R1: Each piece is min(2^BOUND_W − (address mod 2^BOUND_W), bytes left in the segment). No piece spans an aligned 2^BOUND_W window, and no piece is empty.
- R2: After each piece, the address grows by the piece size and the bytes left shrink by the same amount. The pieces of a segment come out in address order until the segment is used up, and segments are handled in arrival order.
- R3: A descriptor is the four words 0, address, 0, length field, in that order. Each word is byte-reversed on the stream: the value's least significant byte appears in bits 31:24. The length field holds the piece size in its low bits, and bits 30 down to BOUND_W+1 are zero.
- R4: Bit 31 of the length field is 1 on the final descriptor of a list only. `desc_last` is high with that fourth word only.
- R5: A list may hold at most CAPACITY descriptors. When one more would be needed, the job aborts. The first CAPACITY−1 descriptors have already been sent without an end marker, and the held-back one is discarded. Further segments up to and including the one flagged last are accepted and produce nothing. The status then shows count 0 and `done_ovf` = 1.
- R6: A segment of length zero ends the list. Later segments, up to the one flagged last, are accepted and ignored. The descriptors made before it are closed normally, with the end marker.
- R7: A list that yields no descriptors sends no words and reports count 0 with `done_ovf` = 0.
- R8: `done_valid` is a one-cycle pulse, once per list. It comes after the list's final word has been accepted, and it carries the number of descriptors sent.
- R9: While `desc_valid` is high and `desc_ready` is low, `desc_word` and `desc_last` hold their values.
- R10: After reset, `seg_ready` is 1 and `desc_valid` and `done_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted this cycle when valid |
| seg_addr | input | 32 | Segment start address |
| seg_len | input | LEN_W | Segment length in bytes |
| seg_last | input | 1 | Final segment of the list |
| desc_valid | output | 1 | Descriptor word offered |
| desc_ready | input | 1 | Descriptor word taken |
| desc_word | output | 32 | Descriptor word, byte-reversed |
| desc_last | output | 1 | Final word of the list's table |
| done_valid | output | 1 | One-cycle status pulse at end of list |
| done_count | output | $clog2(CAPACITY+1) | Descriptors in the table, 0 on overflow |
| done_ovf | output | 1 | Table capacity was exceeded |

## Verification
The bench builds the generator with BOUND_W = 4, LEN_W = 8 and CAPACITY = 5. With a 16-byte window, every start offset inside the window can be combined with lengths from one byte up to several windows. That sweep covers short tails, exact window fits, lists exactly at capacity, and lists one descriptor past it.

Multi-segment lists in this small configuration also exercise two further cases: zero-length segments in different positions, and overflow in the middle of a list followed by draining of the remaining segments. The descriptor output is stalled in an irregular pattern during half of the runs.

// File: rtl/sgl_pkg.sv
package sgl_pkg;

  typedef enum logic [2:0] {
    ST_TAKE,    // waiting for a segment
    ST_CUT,     // carving pieces out of the current segment
    ST_SKIP,    // consuming segments until the list's last one
    ST_CLOSE,   // releasing the held entry with the end marker
    ST_SETTLE   // waiting for the last word, then reporting
  } ctl_state_e;

  function automatic logic [31:0] swap_bytes(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

endpackage

// File: rtl/sgl_piece_calc.sv
module sgl_piece_calc #(
  parameter int LEN_W   = 24,
  parameter int BOUND_W = 16,
  localparam int PIECE_W = BOUND_W + 1,
  localparam int CW      = (LEN_W > PIECE_W) ? LEN_W : PIECE_W
) (
  input  logic [BOUND_W-1:0] addr_lo,
  input  logic [LEN_W-1:0]   remain,
  output logic [PIECE_W-1:0] piece,
  output logic               final_piece
);
  logic [PIECE_W-1:0] room;
  logic [CW-1:0]      room_x;
  logic [CW-1:0]      remain_x;

  always_comb begin
    room        = {1'b1, {BOUND_W{1'b0}}} - {1'b0, addr_lo};
    room_x      = CW'(room);
    remain_x    = CW'(remain);
    final_piece = (remain_x <= room_x);
    piece       = final_piece ? remain_x[PIECE_W-1:0] : room;
  end
endmodule

// File: rtl/sgl_word_tx.sv
module sgl_word_tx
  import sgl_pkg::*;
#(
  parameter int PIECE_W = 17
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld,
  input  logic [31:0]        ld_addr,
  input  logic [PIECE_W-1:0] ld_len,
  input  logic               ld_end,
  output logic               idle,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [31:0]        out_word,
  output logic               out_last
);
  logic [3:0][31:0] sh_q;
  logic [1:0]       idx_q;
  logic             vld_q;
  logic             end_q;
  logic [31:0]      len_field;

  always_comb begin
    len_field     = 32'(ld_len);
    len_field[31] = ld_end;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      idx_q <= '0;
      vld_q <= 1'b0;
      end_q <= 1'b0;
    end else if (ld) begin
      sh_q[0] <= 32'h0;
      sh_q[1] <= swap_bytes(ld_addr);
      sh_q[2] <= 32'h0;
      sh_q[3] <= swap_bytes(len_field);
      idx_q   <= '0;
      vld_q   <= 1'b1;
      end_q   <= ld_end;
    end else if (vld_q && out_ready) begin
      sh_q  <= {32'h0, sh_q[3:1]};
      idx_q <= idx_q + 2'd1;
      if (idx_q == 2'd3) vld_q <= 1'b0;
    end
  end

  assign idle      = !vld_q;
  assign out_valid = vld_q;
  assign out_word  = sh_q[0];
  assign out_last  = vld_q && end_q && (idx_q == 2'd3);
endmodule

// File: rtl/sg_desc_builder.sv
module sg_desc_builder
  import sgl_pkg::*;
#(
  parameter int LEN_W    = 24,
  parameter int BOUND_W  = 16,
  parameter int CAPACITY = 64,
  localparam int PIECE_W = BOUND_W + 1,
  localparam int CNT_W   = $clog2(CAPACITY + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seg_valid,
  output logic              seg_ready,
  input  logic [31:0]       seg_addr,
  input  logic [LEN_W-1:0]  seg_len,
  input  logic              seg_last,
  output logic              desc_valid,
  input  logic              desc_ready,
  output logic [31:0]       desc_word,
  output logic              desc_last,
  output logic              done_valid,
  output logic [CNT_W-1:0]  done_count,
  output logic              done_ovf
);
  ctl_state_e         st_q;
  logic [31:0]        cur_addr_q;
  logic [LEN_W-1:0]   cur_rem_q;
  logic               cur_last_q;
  logic               pend_vld_q;
  logic [31:0]        pend_addr_q;
  logic [PIECE_W-1:0] pend_len_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               ovf_q;
  logic               done_vld_q;
  logic [CNT_W-1:0]   done_cnt_q;
  logic               done_ovf_q;

  logic [PIECE_W-1:0] piece;
  logic               final_piece;
  logic               tx_idle;
  logic               tx_ld;
  logic               tx_end;
  logic               at_cap;
  logic               cut_go;

  sgl_piece_calc #(.LEN_W(LEN_W), .BOUND_W(BOUND_W)) u_calc (
    .addr_lo     (cur_addr_q[BOUND_W-1:0]),
    .remain      (cur_rem_q),
    .piece       (piece),
    .final_piece (final_piece)
  );

  always_comb begin
    at_cap = (cnt_q == CNT_W'(CAPACITY));
    cut_go = (st_q == ST_CUT) && !at_cap && (!pend_vld_q || tx_idle);
    tx_ld  = 1'b0;
    tx_end = 1'b0;
    if (st_q == ST_CUT && !at_cap && pend_vld_q && tx_idle) begin
      tx_ld = 1'b1;
    end else if (st_q == ST_CLOSE && pend_vld_q && tx_idle) begin
      tx_ld  = 1'b1;
      tx_end = 1'b1;
    end
  end

  sgl_word_tx #(.PIECE_W(PIECE_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .ld        (tx_ld),
    .ld_addr   (pend_addr_q),
    .ld_len    (pend_len_q),
    .ld_end    (tx_end),
    .idle      (tx_idle),
    .out_valid (desc_valid),
    .out_ready (desc_ready),
    .out_word  (desc_word),
    .out_last  (desc_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_TAKE;
      cur_addr_q  <= '0;
      cur_rem_q   <= '0;
      cur_last_q  <= 1'b0;
      pend_vld_q  <= 1'b0;
      pend_addr_q <= '0;
      pend_len_q  <= '0;
      cnt_q       <= '0;
      ovf_q       <= 1'b0;
      done_vld_q  <= 1'b0;
      done_cnt_q  <= '0;
      done_ovf_q  <= 1'b0;
    end else begin
      done_vld_q <= 1'b0;
      case (st_q)
        ST_TAKE: begin
          if (seg_valid) begin
            if (seg_len == '0) begin
              st_q <= seg_last ? ST_CLOSE : ST_SKIP;
            end else begin
              cur_addr_q <= seg_addr;
              cur_rem_q  <= seg_len;
              cur_last_q <= seg_last;
              st_q       <= ST_CUT;
            end
          end
        end
        ST_CUT: begin
          if (at_cap) begin
            ovf_q      <= 1'b1;
            pend_vld_q <= 1'b0;
            st_q       <= cur_last_q ? ST_SETTLE : ST_SKIP;
          end else if (cut_go) begin
            pend_vld_q  <= 1'b1;
            pend_addr_q <= cur_addr_q;
            pend_len_q  <= piece;
            cnt_q       <= cnt_q + 1'b1;
            cur_addr_q  <= cur_addr_q + 32'(piece);
            cur_rem_q   <= cur_rem_q - LEN_W'(piece);
            if (final_piece) st_q <= cur_last_q ? ST_CLOSE : ST_TAKE;
          end
        end
        ST_SKIP: begin
          if (seg_valid && seg_last) st_q <= ovf_q ? ST_SETTLE : ST_CLOSE;
        end
        ST_CLOSE: begin
          if (!pend_vld_q || tx_idle) begin
            pend_vld_q <= 1'b0;
            st_q       <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (tx_idle) begin
            done_vld_q <= 1'b1;
            done_cnt_q <= ovf_q ? '0 : cnt_q;
            done_ovf_q <= ovf_q;
            cnt_q      <= '0;
            ovf_q      <= 1'b0;
            st_q       <= ST_TAKE;
          end
        end
        default: st_q <= ST_TAKE;
      endcase
    end
  end

  assign seg_ready  = (st_q == ST_TAKE) || (st_q == ST_SKIP);
  assign done_valid = done_vld_q;
  assign done_count = done_cnt_q;
  assign done_ovf   = done_ovf_q;
endmodule

// File: rtl/sg_desc_checker.sv
module sg_desc_checker
  import sgl_pkg::*;
#(
  parameter int LEN_W    = 24,
  parameter int BOUND_W  = 16,
  parameter int CAPACITY = 64,
  localparam int PIECE_W = BOUND_W + 1,
  localparam int CNT_W   = $clog2(CAPACITY + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             desc_valid,
  input logic             desc_ready,
  input logic [31:0]      desc_word,
  input logic             desc_last,
  input logic             done_valid,
  input logic [CNT_W-1:0] done_count,
  input logic             done_ovf
);
  logic [1:0]         widx_q;
  logic [BOUND_W-1:0] alo_q;
  logic [31:0]        w_val;
  logic [BOUND_W+1:0] span;
  logic               cross_bad;
  logic               hs;

  always_comb begin
    hs        = desc_valid && desc_ready;
    w_val     = swap_bytes(desc_word);
    span      = (BOUND_W+2)'(alo_q) + (BOUND_W+2)'(w_val[BOUND_W:0]);
    cross_bad = (span > (BOUND_W+2)'(1 << BOUND_W)) || (w_val[BOUND_W:0] == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      widx_q <= '0;
      alo_q  <= '0;
    end else if (hs) begin
      widx_q <= widx_q + 2'd1;
      if (widx_q == 2'd1) alo_q <= w_val[BOUND_W-1:0];
    end
  end

  AST_NO_CROSS: assert property (@(posedge clk) disable iff (rst) hs && widx_q == 2'd3 |-> !cross_bad); // R1
  AST_ZERO_WORDS: assert property (@(posedge clk) disable iff (rst) hs && !widx_q[0] |-> desc_word == 32'h0); // R3
  AST_LEN_RESERVED: assert property (@(posedge clk) disable iff (rst) hs && widx_q == 2'd3 |-> w_val[30:PIECE_W] == '0); // R3
  AST_END_ON_FOURTH: assert property (@(posedge clk) disable iff (rst) desc_valid && desc_last |-> widx_q == 2'd3 && w_val[31]); // R4
  AST_OVF_ZERO: assert property (@(posedge clk) disable iff (rst) done_valid && done_ovf |-> done_count == '0); // R5
  AST_CNT_CAP: assert property (@(posedge clk) disable iff (rst) done_valid |-> done_count <= CNT_W'(CAPACITY)); // R5
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst) done_valid |=> !done_valid); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst) done_valid |-> !desc_valid); // R8
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst) desc_valid && !desc_ready |=> desc_valid && $stable(desc_word) && $stable(desc_last)); // R9
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> !desc_valid && !done_valid); // R10
endmodule

bind sg_desc_builder sg_desc_checker #(
  .LEN_W(LEN_W), .BOUND_W(BOUND_W), .CAPACITY(CAPACITY)
) u_sg_desc_checker (
  .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_ready(desc_ready),
  .desc_word(desc_word), .desc_last(desc_last), .done_valid(done_valid),
  .done_count(done_count), .done_ovf(done_ovf)
);

// File: tb/test_sg_desc_builder.sv
module test_sg_desc_builder;
  localparam int LEN_W = 8;
  localparam int BW    = 4;
  localparam int CAP   = 5;
  localparam int CNT_W = $clog2(CAP + 1);
  localparam int WIN   = 1 << BW;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             seg_valid = 1'b0;
  logic             seg_ready;
  logic [31:0]      seg_addr = '0;
  logic [LEN_W-1:0] seg_len = '0;
  logic             seg_last = 1'b0;
  logic             desc_valid;
  logic             desc_ready = 1'b0;
  logic [31:0]      desc_word;
  logic             desc_last;
  logic             done_valid;
  logic [CNT_W-1:0] done_count;
  logic             done_ovf;

  sg_desc_builder #(.LEN_W(LEN_W), .BOUND_W(BW), .CAPACITY(CAP)) i_sg_desc_builder (
    .clk(clk), .rst(rst), .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_addr(seg_addr), .seg_len(seg_len), .seg_last(seg_last),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_word(desc_word),
    .desc_last(desc_last), .done_valid(done_valid), .done_count(done_count),
    .done_ovf(done_ovf)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit bp_en = 1'b0;
  logic [31:0] got_q[$];
  bit          got_last_q[$];
  logic [31:0] exp_q[$];
  bit          exp_last_q[$];
  int exp_cnt;
  bit exp_ovf;
  int done_seen = 0;
  int done_cnt_s;
  bit done_ovf_s;
  int pulse_bad = 0;
  int quiet_bad = 0;
  int stall_seen = 0;
  int stall_bad = 0;
  bit prev_done = 1'b0;
  bit prev_stall = 1'b0;
  logic [31:0] prev_word;
  bit prev_last;
  logic [31:0] sa[4];
  int          sl[4];
  bit          sx[4];

  function automatic logic [31:0] rev8(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit rdy;
    cyc++;
    rdy = bp_en ? ((cyc % 5) != 2 && (cyc % 7) != 3) : 1'b1;
    if (prev_stall) begin
      stall_seen++;
      if (!(desc_valid && desc_word == prev_word && desc_last == prev_last)) stall_bad++;
    end
    desc_ready = rdy;
    prev_stall = desc_valid && !rdy;
    prev_word  = desc_word;
    prev_last  = desc_last;
    if (desc_valid && rdy) begin
      got_q.push_back(desc_word);
      got_last_q.push_back(desc_last);
    end
    if (done_valid) begin
      done_seen++;
      done_cnt_s = int'(done_count);
      done_ovf_s = done_ovf;
      if (prev_done) pulse_bad++;
      if (desc_valid) quiet_bad++;
    end
    prev_done = done_valid;
  end

  task automatic build_exp(input int n_seg);
    logic [31:0] ea[$];
    int el[$];
    int cnt;
    bit ovf;
    bit stop;
    int nem;
    cnt = 0; ovf = 0; stop = 0;
    exp_q.delete(); exp_last_q.delete();
    for (int s = 0; s < n_seg && !stop; s++) begin
      logic [31:0] a;
      int r;
      a = sa[s];
      r = sl[s];
      if (r == 0) stop = 1;
      while (!stop && r > 0) begin
        int ch;
        ch = WIN - int'(a % WIN);
        if (ch > r) ch = r;
        if (cnt == CAP) begin
          ovf = 1; stop = 1;
        end else begin
          ea.push_back(a); el.push_back(ch);
          cnt++; a = a + 32'(ch); r = r - ch;
        end
      end
      if (sx[s]) stop = 1;
    end
    nem = ovf ? CAP - 1 : cnt;
    for (int i = 0; i < nem; i++) begin
      bit eol;
      logic [31:0] lf;
      eol = !ovf && (i == cnt - 1);
      lf = 32'(el[i]);
      lf[31] = eol;
      exp_q.push_back(32'h0);       exp_last_q.push_back(1'b0);
      exp_q.push_back(rev8(ea[i])); exp_last_q.push_back(1'b0);
      exp_q.push_back(32'h0);       exp_last_q.push_back(1'b0);
      exp_q.push_back(rev8(lf));    exp_last_q.push_back(eol);
    end
    exp_cnt = ovf ? 0 : cnt;
    exp_ovf = ovf;
  endtask

  task automatic send_seg(input logic [31:0] a, input int l, input bit last);
    @(negedge clk);
    seg_valid = 1'b1;
    seg_addr  = a;
    seg_len   = l[LEN_W-1:0];
    seg_last  = last;
    while (seg_ready !== 1'b1) @(negedge clk);
    @(negedge clk);
    seg_valid = 1'b0;
  endtask

  task automatic run_list(input int n_seg, input string req);
    int base;
    int waited;
    int bad_i;
    string cnt_req;
    got_q.delete(); got_last_q.delete();
    build_exp(n_seg);
    base = done_seen;
    for (int s = 0; s < n_seg; s++) send_seg(sa[s], sl[s], sx[s]);
    waited = 0;
    while (done_seen == base && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    repeat (2) @(negedge clk);
    check(done_seen == base + 1, "R8", "status pulses per list", done_seen - base, 1);
    if (got_q.size() != exp_q.size()) begin
      check(1'b0, req, "word count", got_q.size(), exp_q.size());
    end else begin
      bad_i = -1;
      for (int i = 0; i < exp_q.size(); i++)
        if (bad_i < 0 && got_q[i] !== exp_q[i]) bad_i = i;
      check(bad_i < 0, req, "descriptor words",
            bad_i < 0 ? 0 : got_q[bad_i], bad_i < 0 ? 0 : exp_q[bad_i]);
      bad_i = -1;
      for (int i = 0; i < exp_q.size(); i++)
        if (bad_i < 0 && got_last_q[i] != exp_last_q[i]) bad_i = i;
      check(bad_i < 0, "R4", "desc_last position", bad_i, -1);
    end
    cnt_req = exp_ovf ? "R5" : (exp_cnt == 0 ? "R7" : "R8");
    check(done_cnt_s == exp_cnt, cnt_req, "done_count", done_cnt_s, exp_cnt);
    check(done_ovf_s == exp_ovf, cnt_req, "done_ovf", done_ovf_s, exp_ovf);
  endtask

  task automatic set_seg(input int s, input logic [31:0] a, input int l, input bit x);
    sa[s] = a; sl[s] = l; sx[s] = x;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int l0s[4];
    int l1s[3];
    int l2s[3];
    l0s = '{1, 7, 16, 20};
    l1s = '{3, 16, 33};
    l2s = '{0, 5, 17};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(seg_ready == 1'b1, "R10", "seg_ready after reset", seg_ready, 1);
    check(desc_valid == 1'b0, "R10", "desc_valid after reset", desc_valid, 0);
    check(done_valid == 1'b0, "R10", "done_valid after reset", done_valid, 0);

    // R1 R2 R3: every offset in the window against many lengths, single segment
    for (int o = 0; o < WIN; o++) begin
      bp_en = o[0];
      for (int l = 1; l <= 72; l++) begin
        set_seg(0, 32'hC0DE_1200 + 32'(o), l, 1'b1);
        run_list(1, "R1,R2,R3");
      end
    end

    // R5 exact capacity and one past it
    bp_en = 1'b1;
    set_seg(0, 32'h0000_4000, 80, 1'b1); run_list(1, "R5");
    set_seg(0, 32'h0000_4000, 81, 1'b1); run_list(1, "R5");
    // R5 overflow in the first of three segments, rest drained
    set_seg(0, 32'h0000_5003, 100, 1'b0);
    set_seg(1, 32'h0000_6000, 20, 1'b0);
    set_seg(2, 32'h0000_7000, 9, 1'b1);
    run_list(3, "R5");
    // R7 lone zero-length segment
    set_seg(0, 32'h0000_8000, 0, 1'b1); run_list(1, "R7");
    // R6 R7 zero-length first, later data ignored
    set_seg(0, 32'h0000_8000, 0, 1'b0);
    set_seg(1, 32'h0000_9000, 30, 1'b1);
    run_list(2, "R6");
    // R6 zero-length in the middle closes the list
    set_seg(0, 32'h0000_A00C, 10, 1'b0);
    set_seg(1, 32'h0000_B000, 0, 1'b0);
    set_seg(2, 32'h0000_C000, 12, 1'b1);
    run_list(3, "R6");

    // R2 R5 R6 multi-segment combinations
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++) begin
          bp_en = (a + b + c) % 2 == 1;
          set_seg(0, 32'h0001_0000 + 32'(a * 5), l0s[a], 1'b0);
          set_seg(1, 32'h0002_0009 + 32'(b * 3), l1s[b], 1'b0);
          set_seg(2, 32'h0003_000F - 32'(c), l2s[c], 1'b1);
          run_list(3, "R2,R5,R6");
        end

    check(stall_bad == 0, "R9", "word changed during stall", stall_bad, 0);
    check(stall_seen > 0, "R9", "stall cycles observed", stall_seen, 1);
    check(pulse_bad == 0, "R8", "done held longer than one cycle", pulse_bad, 0);
    check(quiet_bad == 0, "R8", "words still pending at done", quiet_bad, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule